// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the byte address for a single-register load or store. It takes a base register value and an offset and adds or subtracts one from the other, modulo 2^32. The offset is either a 12-bit unsigned immediate or a second register value. The register value can pass through a barrel shifter first.

An indexing mode decides how the one adder result is used:

- **Pre-indexed:** the sum goes to memory.
- **Pre-indexed with writeback:** the sum goes to memory and also back to the base register.
- **Post-indexed:** the untouched base goes to memory and the sum is returned as the new base.

The block also checks the outgoing address against the access size. A misaligned half-word or word access raises an error flag, and that flag cancels the base update.

The block sits between register read and the memory port. Inputs arrive with a valid strobe, and every result appears one clock later together with its own valid strobe.

Top module: `lsu_ea_gen`

## Requirements
- R1: While `rst` is high, and on the first edge after it is applied, `out_valid`, `wb_en`, `align_err`, `mem_addr` and `wb_data` are all zero.
- R2: `out_valid` equals `in_valid` from the previous clock. `mem_addr` and `wb_data` are loaded only on a valid input and keep their last value while `out_valid` is low.
- R3: `off_sel`=0 selects the zero-extended 12-bit `imm_off` and ignores `reg_off`, `shift_kind` and `shift_amt`. `off_sel`=1 selects the shifted `reg_off` and ignores `imm_off`.
- R4: `shift_kind` encodes the shift applied to `reg_off` by `shift_amt` (0 to 31) as follows: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. An amount of 0 leaves the value unshifted.
- R5: `sub_sel`=0 forms base plus offset and `sub_sel`=1 forms base minus offset, both wrapping modulo 2^32. `wb_data` always carries this sum.
- R6: `mode` 0 (pre-indexed) sends the sum to `mem_addr` with `wb_en` low. The reserved code 3 behaves the same way.
- R7: `mode` 1 (pre-indexed with writeback) sends the sum to `mem_addr` and raises `wb_en` unless `align_err` is set.
- R8: `mode` 2 (post-indexed) sends the unmodified base to `mem_addr` and raises `wb_en` unless `align_err` is set.
- R9: `size` encodes the access width as follows: 0 = byte, 1 = half-word, 2 or 3 = word. `align_err` is set when a word access has `mem_addr[1:0]` non-zero or a half-word access has `mem_addr[0]` set. A byte access never sets it.
- R10: `wb_en` is never high together with `align_err`. Both are low whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| base_val | input | 32 | Base register value |
| reg_off | input | 32 | Register offset value |
| imm_off | input | 12 | Immediate offset magnitude |
| off_sel | input | 1 | 1 = register offset, 0 = immediate |
| sub_sel | input | 1 | 1 = subtract offset, 0 = add |
| shift_kind | input | 2 | Shift applied to the register offset |
| shift_amt | input | 5 | Shift distance |
| mode | input | 2 | Indexing mode |
| size | input | 2 | Access width |
| out_valid | output | 1 | Result strobe |
| mem_addr | output | 32 | Address presented to memory |
| wb_data | output | 32 | New base register value |
| wb_en | output | 1 | Base writeback enable |
| align_err | output | 1 | Misaligned access flag |

## Verification
The first corner case is post-indexed with an aligned base but a misaligned sum. A design that checked alignment on the sum instead of the outgoing address would flag this access and wrongly drop its writeback. The second is arithmetic wraparound: subtraction below zero and a negative arithmetic-shifted offset. A design that extended or saturated the sum would return the wrong address. Further vectors do the following:

- drive a rotate of zero and a rotate that wraps bits to the top;
- drive an immediate of all ones;
- present a junk `reg_off` while the immediate is selected, which catches a broken operand mux;
- use both reserved codes, `mode` 3 and `size` 3;
- send a bubble after a writeback, which exposes an enable that outlives its valid strobe.

// File: rtl/lsu_ea_pkg.sv
package lsu_ea_pkg;

    localparam int XLEN  = 32;
    localparam int SH_W  = $clog2(XLEN);

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        IDX_PRE    = 2'd0,
        IDX_PRE_WB = 2'd1,
        IDX_POST   = 2'd2,
        IDX_RSVD   = 2'd3
    } idx_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wb;
        logic            wb_en;
        logic            err;
    } ea_result_t;

    // Low address bits that must be zero for a given access width.
    function automatic logic [1:0] align_mask(acc_size_e sz);
        case (sz)
            SZ_BYTE: return 2'b00;
            SZ_HALF: return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic mode_writes_back(idx_mode_e m);
        return (m == IDX_PRE_WB) || (m == IDX_POST);
    endfunction

endpackage

// File: rtl/lsu_ea_shift.sv
module lsu_ea_shift
    import lsu_ea_pkg::*;
#(
    parameter int W   = XLEN,
    parameter int AMT = $clog2(W)
) (
    input  logic [W-1:0]   val,
    input  shift_kind_e    kind,
    input  logic [AMT-1:0] amt,
    output logic [W-1:0]   res
);
    logic [2*W-1:0] dbl;

    always_comb begin
        dbl = {val, val} >> amt;
        case (kind)
            SH_LSL:  res = val << amt;
            SH_LSR:  res = val >> amt;
            SH_ASR:  res = W'($signed(val) >>> amt);
            default: res = dbl[W-1:0];
        endcase
    end
endmodule

// File: rtl/lsu_ea_addsub.sv
module lsu_ea_addsub #(
    parameter int W     = 32,
    parameter int IMM_W = 12
) (
    input  logic [W-1:0]     base,
    input  logic [W-1:0]     reg_term,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_reg,
    input  logic             subtract,
    output logic [W-1:0]     sum
);
    logic [W-1:0] operand;

    always_comb begin
        operand = use_reg ? reg_term : {{(W-IMM_W){1'b0}}, imm};
        sum     = subtract ? (base - operand) : (base + operand);
    end
endmodule

// File: rtl/lsu_ea_align.sv
module lsu_ea_align
    import lsu_ea_pkg::*;
(
    input  acc_size_e  sz,
    input  logic [1:0] addr_lo,
    output logic       misaligned
);
    always_comb misaligned = |(addr_lo & align_mask(sz));
endmodule

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
    import lsu_ea_pkg::*;
#(
    parameter int IMM_W = 12,
    parameter int AW    = XLEN,
    localparam int SW   = $clog2(AW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [AW-1:0]   base_val,
    input  logic [AW-1:0]   reg_off,
    input  logic [IMM_W-1:0] imm_off,
    input  logic            off_sel,
    input  logic            sub_sel,
    input  logic [1:0]      shift_kind,
    input  logic [SW-1:0]   shift_amt,
    input  logic [1:0]      mode,
    input  logic [1:0]      size,
    output logic            out_valid,
    output logic [AW-1:0]   mem_addr,
    output logic [AW-1:0]   wb_data,
    output logic            wb_en,
    output logic            align_err
);
    idx_mode_e    mode_e;
    acc_size_e    size_e;
    shift_kind_e  kind_e;
    logic [AW-1:0] shifted, sum, sent;
    logic          misaligned;
    ea_result_t    res_q;
    logic          vld_q;

    always_comb begin
        mode_e = idx_mode_e'(mode);
        size_e = acc_size_e'(size);
        kind_e = shift_kind_e'(shift_amt == '0 ? SH_LSL : shift_kind);
    end

    lsu_ea_shift #(.W(AW), .AMT(SW)) u_shift (
        .val  (reg_off),
        .kind (kind_e),
        .amt  (shift_amt),
        .res  (shifted)
    );

    lsu_ea_addsub #(.W(AW), .IMM_W(IMM_W)) u_addsub (
        .base     (base_val),
        .reg_term (shifted),
        .imm      (imm_off),
        .use_reg  (off_sel),
        .subtract (sub_sel),
        .sum      (sum)
    );

    always_comb sent = (mode_e == IDX_POST) ? base_val : sum;

    lsu_ea_align u_align (
        .sz         (size_e),
        .addr_lo    (sent[1:0]),
        .misaligned (misaligned)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q.addr  <= sent;
                res_q.wb    <= sum;
                res_q.err   <= misaligned;
                res_q.wb_en <= mode_writes_back(mode_e) && !misaligned;
            end else begin
                res_q.err   <= 1'b0;
                res_q.wb_en <= 1'b0;
            end
        end
    end

    always_comb begin
        out_valid = vld_q;
        mem_addr  = res_q.addr;
        wb_data   = res_q.wb;
        wb_en     = res_q.wb_en;
        align_err = res_q.err;
    end

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R10
    wb_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (!align_err && out_valid));

    // R10
    err_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        align_err |-> out_valid);

    // R8
    post_base_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid && $past(mode) == IDX_POST) |-> (mem_addr == $past(base_val)));

    // R6
    pre_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid && ($past(mode) == IDX_PRE || $past(mode) == IDX_RSVD)) |-> !wb_en);

    // R9
    byte_never_err_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid && $past(size) == SZ_BYTE) |-> !align_err);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> ($stable(mem_addr) && $stable(wb_data)));

endmodule

// File: tb/lsu_ea_gen_test.sv
module lsu_ea_gen_test;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] roff;
        logic [11:0] imm;
        logic        osel;
        logic        sub;
        logic [1:0]  sk;
        logic [4:0]  sa;
        logic [1:0]  md;
        logic [1:0]  sz;
        logic [31:0] e_addr;
        logic [31:0] e_wb;
        logic        e_wben;
        logic        e_err;
    } vec_t;

    localparam int NV = 16;
    // mode: 0 pre, 1 pre+wb, 2 post, 3 rsvd; size: 0 byte, 1 half, 2/3 word; sk: 0 lsl 1 lsr 2 asr 3 ror
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 32'h0, 12'h010, 1'b0, 1'b0, 2'd0, 5'd0, 2'd0, 2'd2, 32'h0000_1010, 32'h0000_1010, 1'b0, 1'b0},
        '{32'h0000_1000, 32'h0, 12'h004, 1'b0, 1'b1, 2'd0, 5'd0, 2'd1, 2'd2, 32'h0000_0FFC, 32'h0000_0FFC, 1'b1, 1'b0},
        '{32'h0000_2000, 32'h0, 12'h008, 1'b0, 1'b0, 2'd0, 5'd0, 2'd2, 2'd2, 32'h0000_2000, 32'h0000_2008, 1'b1, 1'b0},
        '{32'h0000_0100, 32'h3, 12'h000, 1'b1, 1'b0, 2'd0, 5'd4, 2'd1, 2'd2, 32'h0000_0130, 32'h0000_0130, 1'b1, 1'b0},
        '{32'h0000_0000, 32'h8000_0000, 12'h000, 1'b1, 1'b0, 2'd1, 5'd1, 2'd0, 2'd2, 32'h4000_0000, 32'h4000_0000, 1'b0, 1'b0},
        '{32'h0000_1000, 32'hFFFF_FF00, 12'h000, 1'b1, 1'b0, 2'd2, 5'd4, 2'd0, 2'd2, 32'h0000_0FF0, 32'h0000_0FF0, 1'b0, 1'b0},
        '{32'h0000_0001, 32'h0000_00AB, 12'h000, 1'b1, 1'b0, 2'd3, 5'd8, 2'd0, 2'd0, 32'hAB00_0001, 32'hAB00_0001, 1'b0, 1'b0},
        '{32'h0000_0002, 32'h0, 12'h006, 1'b0, 1'b1, 2'd0, 5'd0, 2'd1, 2'd1, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1'b1, 1'b0},
        '{32'h0000_1000, 32'h0, 12'h002, 1'b0, 1'b0, 2'd0, 5'd0, 2'd1, 2'd2, 32'h0000_1002, 32'h0000_1002, 1'b0, 1'b1},
        '{32'h0000_1001, 32'h0, 12'h000, 1'b0, 1'b0, 2'd0, 5'd0, 2'd2, 2'd1, 32'h0000_1001, 32'h0000_1001, 1'b0, 1'b1},
        '{32'h0000_1000, 32'h0, 12'h001, 1'b0, 1'b0, 2'd0, 5'd0, 2'd2, 2'd2, 32'h0000_1000, 32'h0000_1001, 1'b1, 1'b0},
        '{32'h0000_0000, 32'h0, 12'hFFF, 1'b0, 1'b0, 2'd0, 5'd0, 2'd0, 2'd0, 32'h0000_0FFF, 32'h0000_0FFF, 1'b0, 1'b0},
        '{32'h0000_0100, 32'hDEAD_BEEF, 12'h020, 1'b0, 1'b0, 2'd3, 5'd7, 2'd0, 2'd2, 32'h0000_0120, 32'h0000_0120, 1'b0, 1'b0},
        '{32'h0000_0040, 32'h0, 12'h004, 1'b0, 1'b0, 2'd0, 5'd0, 2'd3, 2'd2, 32'h0000_0044, 32'h0000_0044, 1'b0, 1'b0},
        '{32'h0000_0000, 32'h0, 12'h002, 1'b0, 1'b0, 2'd0, 5'd0, 2'd0, 2'd3, 32'h0000_0002, 32'h0000_0002, 1'b0, 1'b1},
        '{32'h0000_0010, 32'h5, 12'hABC, 1'b1, 1'b0, 2'd3, 5'd0, 2'd0, 2'd0, 32'h0000_0015, 32'h0000_0015, 1'b0, 1'b0}
    };
    localparam string TAGS [NV] = '{
        "R6", "R5 R7", "R8", "R3 R4", "R4", "R4 R5", "R4 R9", "R5 R9",
        "R9 R10", "R8 R9 R10", "R8 R9", "R3", "R3", "R6", "R9", "R4"
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] base_val = '0, reg_off = '0;
    logic [11:0] imm_off = '0;
    logic        off_sel = 1'b0, sub_sel = 1'b0;
    logic [1:0]  shift_kind = '0, mode = '0, size = '0;
    logic [4:0]  shift_amt = '0;
    logic        out_valid, wb_en, align_err;
    logic [31:0] mem_addr, wb_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lsu_ea_gen uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .base_val(base_val), .reg_off(reg_off), .imm_off(imm_off),
        .off_sel(off_sel), .sub_sel(sub_sel), .shift_kind(shift_kind),
        .shift_amt(shift_amt), .mode(mode), .size(size),
        .out_valid(out_valid), .mem_addr(mem_addr), .wb_data(wb_data),
        .wb_en(wb_en), .align_err(align_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid   = 1'b1;
        base_val   = v.base;
        reg_off    = v.roff;
        imm_off    = v.imm;
        off_sel    = v.osel;
        sub_sel    = v.sub;
        shift_kind = v.sk;
        shift_amt  = v.sa;
        mode       = v.md;
        size       = v.sz;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid", 32'(out_valid), 32'd0);
        chk("R1", "wb_en", 32'(wb_en), 32'd0);
        chk("R1", "align_err", 32'(align_err), 32'd0);
        chk("R1", "mem_addr", mem_addr, 32'd0);
        chk("R1", "wb_data", wb_data, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            chk(TAGS[i], "out_valid R2", 32'(out_valid), 32'd1);
            chk(TAGS[i], "mem_addr", mem_addr, VECS[i].e_addr);
            chk(TAGS[i], "wb_data", wb_data, VECS[i].e_wb);
            chk(TAGS[i], "wb_en", 32'(wb_en), 32'(VECS[i].e_wben));
            chk(TAGS[i], "align_err", 32'(align_err), 32'(VECS[i].e_err));
        end

        // R2/R10: a writeback request followed by a bubble
        drive(VECS[1]);
        @(negedge clk);
        in_valid = 1'b0;
        base_val = 32'h5555_0000;
        mode     = 2'd1;
        size     = 2'd2;
        imm_off  = 12'h003;
        @(negedge clk);
        chk("R2", "out_valid bubble", 32'(out_valid), 32'd0);
        chk("R2", "mem_addr hold", mem_addr, 32'h0000_0FFC);
        chk("R2", "wb_data hold", wb_data, 32'h0000_0FFC);
        chk("R10", "wb_en bubble", 32'(wb_en), 32'd0);
        chk("R10", "align_err bubble", 32'(align_err), 32'd0);

        // R1: reset while a valid request is presented
        drive(VECS[8]);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
        chk("R1", "align_err in reset", 32'(align_err), 32'd0);
        chk("R1", "mem_addr in reset", mem_addr, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "align_err after reset", 32'(align_err), 32'd1);
        chk("R10", "wb_en after reset", 32'(wb_en), 32'd0);
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule